// File: doc/BRIEF.md
# Programmable Audio Bit-Clock Divider

This block produces the serial bit clock of an audio serial port from one of two oversample clocks. A select input chooses the crystal-oscillator clock or the external audio clock. A 3-bit ratio code, together with a scale flag, sets the division ratio. The ratios are powers of two plus a family with a factor of three. When the scale flag is 0, every ratio is four times larger. One code gives a divide-by-one pass-through, and one code is reserved.

The divided clock leaves the block on `bclk_out`, which goes both to the shift register and to the external bit-clock pin. A one-cycle strobe, `shift_en`, marks each falling edge of the bit clock so that the shift register can run on the oversample clock. When `master` is 0, the bit clock comes from outside the chip. The divider then stays silent and ignores its ratio settings.

The controller is a four-state machine:
- `S_IDLE`: output held low.
- `S_HIGH`: high half-period.
- `S_LOW`: low half-period.
- `S_THRU`: divide-by-one pass-through.

The transitions are:
- `start` (IDLE→HIGH), `enter_thru` (IDLE→THRU) and `hold` (IDLE→IDLE), taken according to the current settings.
- `half_done` (HIGH→LOW).
- `period_end` (LOW→HIGH, LOW→THRU or LOW→IDLE). New settings are loaded only here.
- `leave_thru` (THRU→IDLE), taken when the settings no longer ask for pass-through.

Top module: `abd_bitclk_gen`

## Requirements
- R1: With `ext_div`=1, codes 3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b101 and 3'b110 give bit-clock periods of 1, 2, 4, 8, 16, 6 and 12 source cycles.
- R2: With `ext_div`=0, the same codes give periods of 4, 8, 16, 32, 64, 24 and 48 source cycles.
- R3: Code 3'b111 with `master`=1 sets `cfg_err` to 1 and holds `bclk_out` and `shift_en` low. This applies with either value of `ext_div`.
- R4: With `master`=0, `bclk_out`, `shift_en` and `cfg_err` stay low whatever the ratio code, including 3'b111.
- R5: `src_sel`=0 divides `clk_xtal`, and `src_sel`=1 divides `clk_audio`.
- R6: For every ratio above one, `bclk_out` is high for exactly half of its period. For ratio one, `bclk_out` follows the source clock, high during the source clock's high phase.
- R7: For ratios above one, `shift_en` is high for exactly one source cycle per bit period. That cycle is the one that begins at the falling edge of `bclk_out`. In pass-through, `shift_en` stays at 1.
- R8: A change of `ratio_code` or `ext_div` made in the middle of a period does not affect that period. Its remaining high and low phases keep the old length, and the new ratio starts at the next rising edge.
- R9: `rst_n`=0 clears the block at once. `bclk_out` and `shift_en` are then low.
- R10: `cfg_err` is registered. It follows the code and `master` one source cycle later, and it does not wait for a period end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_xtal | input | 1 | Oversample clock from the crystal oscillator |
| clk_audio | input | 1 | Oversample clock from the external audio clock pin |
| src_sel | input | 1 | Source select: 0 selects crystal, 1 selects audio clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio_code | input | 3 | Division ratio code |
| ext_div | input | 1 | Scale flag: 0 multiplies every ratio by four |
| master | input | 1 | 1 means the block drives the bit clock; 0 means it is supplied externally |
| bclk_out | output | 1 | Serial bit clock, to the shift register and to the pin |
| shift_en | output | 1 | One-cycle strobe at each falling edge of the bit clock |
| cfg_err | output | 1 | Reserved ratio code selected |

## Verification
Every legal code is run with both scale settings. On each, the bench times the rising-to-rising and rising-to-falling intervals of `bclk_out`. This separates the power-of-two ratios from the factor-of-three ratios, and it catches a wrong scale or a wrong half count through the duty cycle. The reserved code is driven with both scale values and with `master` low, which tells a silenced output apart from an error report. A ratio switch in the middle of a long period checks that the old high and low phases finish unchanged before the new rate starts. A run with the audio clock selected, whose period differs from the crystal's, shows which source is being divided.

// File: rtl/abd_pkg.sv
`timescale 1ns/1ps
package abd_pkg;
    localparam int CODE_W = 3;
    localparam int CNT_W  = 6;
    typedef enum logic [1:0] {S_IDLE, S_HIGH, S_LOW, S_THRU} div_state_e;
endpackage

// File: rtl/abd_src_mux.sv
`timescale 1ns/1ps
module abd_src_mux (
    input  logic clk_xtal,
    input  logic clk_audio,
    input  logic sel,
    output logic clk_src
);
    // R5: selection is static in use; changed only while reset is held
    assign clk_src = sel ? clk_audio : clk_xtal;
endmodule

// File: rtl/abd_ratio_decode.sv
`timescale 1ns/1ps
module abd_ratio_decode #(
    parameter int CODE_W = abd_pkg::CODE_W,
    parameter int CNT_W  = abd_pkg::CNT_W
) (
    input  logic [CODE_W-1:0] code,
    input  logic              ext_div,
    output logic [CNT_W-1:0]  half,
    output logic              thru,
    output logic              illegal
);
    localparam logic [CODE_W-1:0] CODE_RSVD = '1;
    logic [CNT_W-1:0] base;

    always_comb begin
        unique case (code)
            CODE_W'(0): base = CNT_W'(1);
            CODE_W'(1): base = CNT_W'(2);
            CODE_W'(2): base = CNT_W'(4);
            CODE_W'(3): base = CNT_W'(8);
            CODE_W'(4): base = CNT_W'(16);
            CODE_W'(5): base = CNT_W'(6);
            CODE_W'(6): base = CNT_W'(12);
            default:    base = '0;
        endcase
        illegal = (code == CODE_RSVD);
        thru    = ext_div && (code == '0);
        // half period: base/2 when unscaled, base*4/2 when scaled by four
        half    = ext_div ? (base >> 1) : (base << 1);
    end
endmodule

// File: rtl/abd_div_fsm.sv
`timescale 1ns/1ps
module abd_div_fsm #(
    parameter int CNT_W = abd_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master,
    input  logic             illegal,
    input  logic             thru,
    input  logic [CNT_W-1:0] half,
    output logic             bclk,
    output logic             shift_en,
    output logic             cfg_err
);
    import abd_pkg::*;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    div_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, half_q, half_d;
    logic             boundary;
    logic             bclk_q, strobe_q, err_q, pass_en;

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        half_d   = half_q;
        boundary = 1'b0;
        unique case (state_q)
            S_IDLE: boundary = 1'b1;
            S_THRU: if (!master || illegal || !thru) state_d = S_IDLE; // leave_thru
            S_HIGH: begin
                if (cnt_q == '0) begin                                 // half_done
                    state_d = S_LOW;
                    cnt_d   = half_q - ONE;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            S_LOW: begin
                if (cnt_q == '0) boundary = 1'b1;                      // period_end
                else             cnt_d = cnt_q - ONE;
            end
            default: state_d = S_IDLE;
        endcase
        if (boundary) begin
            if (!master || illegal) begin
                state_d = S_IDLE;                                      // hold
            end else if (thru) begin
                state_d = S_THRU;                                      // enter_thru
            end else begin
                state_d = S_HIGH;                                      // start
                half_d  = half;
                cnt_d   = half - ONE;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            half_q  <= ONE;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            half_q  <= half_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q   <= 1'b0;
            strobe_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            bclk_q   <= (state_d == S_HIGH);
            strobe_q <= ((state_d == S_LOW) && (state_q != S_LOW)) || (state_d == S_THRU);
            err_q    <= master && illegal;
        end
    end

    // pass-through gate enable changes only while the source clock is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) pass_en <= 1'b0;
        else        pass_en <= (state_q == S_THRU);
    end

    assign bclk     = bclk_q | (clk & pass_en);
    assign shift_en = strobe_q;
    assign cfg_err  = err_q;

    // R7
    strobe_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bclk_q) |-> strobe_q);
    // R7
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_q && state_q == S_LOW) |=> (!strobe_q || state_q == S_THRU));
    // R8
    ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HIGH) |=> $stable(half_q));
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && (!master || illegal)) |=> (!bclk_q && state_q == S_IDLE));
    // R7
    thru_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_THRU) |-> strobe_q);
endmodule

// File: rtl/abd_bitclk_gen.sv
`timescale 1ns/1ps
module abd_bitclk_gen #(
    parameter int CODE_W = abd_pkg::CODE_W,
    parameter int CNT_W  = abd_pkg::CNT_W
) (
    input  logic              clk_xtal,
    input  logic              clk_audio,
    input  logic              src_sel,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] ratio_code,
    input  logic              ext_div,
    input  logic              master,
    output logic              bclk_out,
    output logic              shift_en,
    output logic              cfg_err
);
    logic             clk_src;
    logic [CNT_W-1:0] half;
    logic             thru, illegal;

    abd_src_mux u_mux (
        .clk_xtal (clk_xtal),
        .clk_audio(clk_audio),
        .sel      (src_sel),
        .clk_src  (clk_src)
    );

    abd_ratio_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_dec (
        .code   (ratio_code),
        .ext_div(ext_div),
        .half   (half),
        .thru   (thru),
        .illegal(illegal)
    );

    abd_div_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk     (clk_src),
        .rst_n   (rst_n),
        .master  (master),
        .illegal (illegal),
        .thru    (thru),
        .half    (half),
        .bclk    (bclk_out),
        .shift_en(shift_en),
        .cfg_err (cfg_err)
    );
endmodule

// File: tb/abd_bitclk_gen_test.sv
`timescale 1ns/1ps
module abd_bitclk_gen_test;
    logic       clk_xtal = 1'b0, clk_audio = 1'b0;
    logic       src_sel = 1'b0, rst_n = 1'b0, ext_div = 1'b1, master = 1'b1;
    logic [2:0] ratio_code = 3'd1;
    logic       bclk_out, shift_en, cfg_err;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #4 clk_xtal  = ~clk_xtal;   // 125 MHz
    always #5 clk_audio = ~clk_audio;  // 100 MHz

    abd_bitclk_gen uut (
        .clk_xtal(clk_xtal), .clk_audio(clk_audio), .src_sel(src_sel),
        .rst_n(rst_n), .ratio_code(ratio_code), .ext_div(ext_div),
        .master(master), .bclk_out(bclk_out), .shift_en(shift_en),
        .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [2:0] c, input logic e, input logic m);
        @(negedge clk_xtal);
        ratio_code = c; ext_div = e; master = m;
    endtask

    // R9: reset state
    task automatic t_reset();
        #3;
        chk("R9 bclk_out in reset", bclk_out, 0);
        chk("R9 shift_en in reset", shift_en, 0);
        repeat (2) @(negedge clk_xtal);
        rst_n = 1'b1;
    endtask

    // R1 R2 R6 R7: period, duty and strobe for one legal setting
    task automatic t_ratio(input logic [2:0] c, input logic e, input int ratio, input string rq);
        time t0, t1, t2;
        int  nstb, nbad;
        set_cfg(c, e, 1'b1);
        repeat (3) @(posedge bclk_out);
        t0 = $time;
        @(negedge bclk_out); t1 = $time;
        @(posedge bclk_out); t2 = $time;
        chk($sformatf("%s period code=%0d ext=%0d", rq, c, e), t2 - t0, 8 * ratio);
        chk($sformatf("R6 high time code=%0d ext=%0d", c, e), t1 - t0, 4 * ratio);
        nstb = 0; nbad = 0;
        for (int i = 0; i < ratio; i++) begin
            @(negedge clk_xtal);
            if (shift_en) begin
                nstb++;
                if (bclk_out) nbad++;
            end
        end
        chk($sformatf("R7 strobes per period code=%0d ext=%0d", c, e), nstb, 1);
        chk($sformatf("R7 strobe while bclk high code=%0d ext=%0d", c, e), nbad, 0);
    endtask

    // R3 / R4 / R10: reserved code and slave mode
    task automatic t_silent(input logic [2:0] c, input logic e, input logic m, input string rq);
        int nhi, nstb;
        set_cfg(c, e, m);
        repeat (80) @(negedge clk_xtal);
        nhi = 0; nstb = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk_xtal);
            if (bclk_out) nhi++;
            if (shift_en) nstb++;
        end
        chk($sformatf("%s bclk high samples code=%0d m=%0d", rq, c, m), nhi, 0);
        chk($sformatf("%s strobe samples code=%0d m=%0d", rq, c, m), nstb, 0);
        chk($sformatf("%s cfg_err code=%0d m=%0d", rq, c, m), cfg_err, (m && c == 3'd7) ? 1 : 0);
    endtask

    // R10: error flag one cycle after code change
    task automatic t_err_timing();
        set_cfg(3'd4, 1'b0, 1'b1);
        repeat (3) @(negedge clk_xtal);
        ratio_code = 3'd7;
        @(negedge clk_xtal);
        chk("R10 cfg_err one cycle after code 111", cfg_err, 1);
        ratio_code = 3'd4;
        @(negedge clk_xtal);
        chk("R10 cfg_err clears one cycle later", cfg_err, 0);
    endtask

    // R8: change in mid period
    task automatic t_change();
        time t0, t1, t2, t3;
        set_cfg(3'd4, 1'b0, 1'b1);
        repeat (3) @(posedge bclk_out);
        t0 = $time;
        repeat (10) @(negedge clk_xtal);
        ratio_code = 3'd1; ext_div = 1'b1;
        @(negedge bclk_out); t1 = $time;
        @(posedge bclk_out); t2 = $time;
        @(posedge bclk_out); t3 = $time;
        chk("R8 old high phase kept", t1 - t0, 256);
        chk("R8 old low phase kept", t2 - t1, 256);
        chk("R8 new period after boundary", t3 - t2, 16);
    endtask

    // R5: audio source
    task automatic t_source();
        time t0, t2;
        @(negedge clk_xtal); rst_n = 1'b0;
        src_sel = 1'b1; ratio_code = 3'd1; ext_div = 1'b1; master = 1'b1;
        repeat (2) @(negedge clk_xtal); rst_n = 1'b1;
        repeat (3) @(posedge bclk_out);
        t0 = $time;
        @(posedge bclk_out); t2 = $time;
        chk("R5 audio source /2 period", t2 - t0, 20);
    endtask

    initial begin
        t_reset();
        t_ratio(3'd0, 1'b1, 1,  "R1");
        t_ratio(3'd1, 1'b1, 2,  "R1");
        t_ratio(3'd2, 1'b1, 4,  "R1");
        t_ratio(3'd3, 1'b1, 8,  "R1");
        t_ratio(3'd4, 1'b1, 16, "R1");
        t_ratio(3'd5, 1'b1, 6,  "R1");
        t_ratio(3'd6, 1'b1, 12, "R1");
        t_ratio(3'd0, 1'b0, 4,  "R2");
        t_ratio(3'd1, 1'b0, 8,  "R2");
        t_ratio(3'd2, 1'b0, 16, "R2");
        t_ratio(3'd3, 1'b0, 32, "R2");
        t_ratio(3'd4, 1'b0, 64, "R2");
        t_ratio(3'd5, 1'b0, 24, "R2");
        t_ratio(3'd6, 1'b0, 48, "R2");
        t_silent(3'd7, 1'b1, 1'b1, "R3");
        t_silent(3'd7, 1'b0, 1'b1, "R3");
        t_silent(3'd2, 1'b1, 1'b0, "R4");
        t_silent(3'd7, 1'b0, 1'b0, "R4");
        t_err_timing();
        t_change();
        t_source();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_xtal);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog (R1..) actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule